// File: doc/BRIEF.md
# Packed-Control Performance Counter Block

This block counts processor activity. It holds one free-running cycle counter and two event counters, all 32 bits wide. Each event counter watches one line of a 256-wide vector of single-cycle event pulses, and an 8-bit code in the control word chooses that line. Code 0xFF chooses no line. For example, a core can route instruction-cache misses to line 0x00, executed branches to 0x05, mispredicted branches to 0x06, retired instructions to 0x07 and data-cache misses to 0x0B.

Software reaches the block through a small register port with four word addresses: 0 is the control word, 1 is the cycle counter, 2 is event counter 0 and 3 is event counter 1. Reads are combinational. A write takes effect at the next rising clock edge. The control word holds all of the following in one register:
- the global enable;
- the self-clearing counter resets;
- the cycle prescale select;
- the interrupt enables;
- the sticky overflow flags;
- both event codes.

Software clears the flags by writing the control value it read back, so no separate acknowledge register is needed. A single level interrupt reports every enabled overflow.

Top module: `perf_mon`

## Requirements
- R1: After reset all three counters read 0, the control word reads 0x0FFFF000 (both event codes 0xFF, everything else 0), and irq is low.
- R2: While control bit 0 is 0, no counter advances.
- R3: With bit 0 set, the cycle counter advances on every clock while bit 3 is 0. While bit 3 is 1 it advances once per 64 enabled clocks, and a 6-bit prescaler sets that pace.
- R4: Event counter 0 uses the code in bits 19:12 and event counter 1 uses the code in bits 27:20. Each counter advances on a clock where evt_i[code] is high. Code 0xFF never advances its counter.
- R5: Writing 1 to control bit 1 zeroes both event counters at that edge. Writing 1 to bit 2 zeroes the cycle counter and the prescaler at that edge. Both bits always read back as 0.
- R6: A counter that advances from 0xFFFFFFFF becomes 0 and sets its overflow flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R7: Writing 1 to a flag bit clears that flag. If the flag is also being set on the same edge, the set wins.
- R8: irq is high exactly when some flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R9: Bits 7, 11 and 31:28 of the control word ignore writes and read as 0.
- R10: A write to a counter address loads wdata at that edge. The write beats any increment on the same edge and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 256 | Event pulse vector, indexed by event code |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land on the same edge. The first pair is a direct counter write and an increment. The second pair is a write-back that clears a flag and a wrap that sets the same flag. The bench causes the first by loading counters while event pulses are held high. It causes the second by loading event counter 1 with 0xFFFFFFFF and then, on the very next edge, writing a flag-clearing control word while the selected event line stays high. A behavioural model in the bench predicts the read data and irq on every clock. In these cases it expects the written value to stick with no flag, and the new overflow flag to survive the clear.

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int CW    = 32,
  parameter int EW    = 8,
  parameter int PRE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [(1<<EW)-1:0] evt_i,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [EW-1:0] NONE = '1;
  localparam logic [CW-1:0] TOP  = '1;

  logic          en, div;
  logic [2:0]    ie, ovf;
  logic [EW-1:0] sel0, sel1;
  logic [CW-1:0] ccnt, ec0, ec1;
  logic [PRE_W-1:0] pre;

  wire ctl_wr  = wr_en && addr == 2'd0;
  wire cyc_wr  = wr_en && addr == 2'd1;
  wire e0_wr   = wr_en && addr == 2'd2;
  wire e1_wr   = wr_en && addr == 2'd3;
  wire cyc_rst = ctl_wr && wdata[2];
  wire evt_rst = ctl_wr && wdata[1];

  wire tick = en && (!div || &pre);
  wire hit0 = en && sel0 != NONE && evt_i[sel0];
  wire hit1 = en && sel1 != NONE && evt_i[sel1];

  wire [2:0] wrap = {tick && ccnt == TOP && !cyc_wr && !cyc_rst,
                     hit1 && ec1 == TOP && !e1_wr && !evt_rst,
                     hit0 && ec0 == TOP && !e0_wr && !evt_rst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; div <= 1'b0; ie <= '0; ovf <= '0;
      sel0 <= NONE; sel1 <= NONE;
    end else begin
      if (ctl_wr) begin
        en   <= wdata[0];
        div  <= wdata[3];
        ie   <= wdata[6:4];
        sel0 <= wdata[12 +: EW];
        sel1 <= wdata[20 +: EW];
        ovf  <= (ovf & ~wdata[10:8]) | wrap;
      end else begin
        ovf  <= ovf | wrap;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (cyc_rst) pre <= '0;
    else if (en && div) pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt <= '0; ec0 <= '0; ec1 <= '0;
    end else begin
      if (cyc_wr) ccnt <= wdata[CW-1:0];
      else if (cyc_rst) ccnt <= '0;
      else if (tick) ccnt <= ccnt + 1'b1;

      if (e0_wr) ec0 <= wdata[CW-1:0];
      else if (evt_rst) ec0 <= '0;
      else if (hit0) ec0 <= ec0 + 1'b1;

      if (e1_wr) ec1 <= wdata[CW-1:0];
      else if (evt_rst) ec1 <= '0;
      else if (hit1) ec1 <= ec1 + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {4'b0, sel1, sel0, 1'b0, ovf, 1'b0, ie, div, 2'b0, en};
      2'd1:    rdata = 32'(ccnt);
      2'd2:    rdata = 32'(ec0);
      default: rdata = 32'(ec1);
    endcase
  end

  assign irq = |(ovf & ie);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(ccnt) && $stable(ec0) && $stable(ec1)));
  // R4
  none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == NONE && !wr_en) |=> $stable(ec0));
  // R5
  evt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[1]) |=> (ec0 == '0 && ec1 == '0));
  // R6
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ccnt == TOP && !wr_en) |=> (ccnt == '0 && ovf[2]));
  // R10
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> (ccnt == $past(wdata[CW-1:0])));
endmodule

// File: tb/perf_mon_bench.sv
module perf_mon_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [255:0] evt = '0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #10 clk = ~clk;

  perf_mon u_perf_mon (.clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(we),
                       .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int checks = 0, errors = 0;
  string phase = "R1";

  bit m_en, m_div;
  bit [2:0] m_ie, m_ovf;
  bit [7:0] m_s0, m_s1;
  longint m_c, m_e0, m_e1;
  int m_pre;
  localparam longint MAXV = 64'hFFFF_FFFF;

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_s1, m_s0, 1'b0, m_ovf, 1'b0, m_ie, m_div, 2'b0, m_en};
      2'd1: return m_c[31:0];
      2'd2: return m_e0[31:0];
      default: return m_e1[31:0];
    endcase
  endfunction

  always @(posedge clk) begin
    bit cw, tick;
    bit [2:0] setf;
    logic [31:0] er;
    if (!rst_n) begin
      m_en = 0; m_div = 0; m_ie = 0; m_ovf = 0; m_s0 = 8'hFF; m_s1 = 8'hFF;
      m_c = 0; m_e0 = 0; m_e1 = 0; m_pre = 0;
    end else begin
      cw = we && addr == 0;
      tick = m_en && (!m_div || m_pre == 63);
      setf = 0;
      if (we && addr == 1) m_c = wdata;
      else if (cw && wdata[2]) m_c = 0;
      else if (tick) begin
        if (m_c == MAXV) begin m_c = 0; setf[2] = 1; end else m_c++;
      end
      if (we && addr == 2) m_e0 = wdata;
      else if (cw && wdata[1]) m_e0 = 0;
      else if (m_en && m_s0 != 8'hFF && evt[m_s0]) begin
        if (m_e0 == MAXV) begin m_e0 = 0; setf[0] = 1; end else m_e0++;
      end
      if (we && addr == 3) m_e1 = wdata;
      else if (cw && wdata[1]) m_e1 = 0;
      else if (m_en && m_s1 != 8'hFF && evt[m_s1]) begin
        if (m_e1 == MAXV) begin m_e1 = 0; setf[1] = 1; end else m_e1++;
      end
      if (cw && wdata[2]) m_pre = 0;
      else if (m_en && m_div) m_pre = (m_pre + 1) % 64;
      if (cw) begin
        m_ovf = m_ovf & ~wdata[10:8];
        m_en = wdata[0]; m_div = wdata[3]; m_ie = wdata[6:4];
        m_s0 = wdata[19:12]; m_s1 = wdata[27:20];
      end
      m_ovf = m_ovf | setf;
      #5;
      er = exp_read(addr);
      checks++;
      if (rdata !== er) begin
        errors++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", phase, addr, rdata, er);
      end
      checks++;
      if (irq !== |(m_ovf & m_ie)) begin
        errors++;
        $display("FAIL %s irq actual=%b expected=%b", phase, irq, |(m_ovf & m_ie));
      end
    end
  end

  function automatic logic [31:0] ctl(bit en, bit div, bit [2:0] ie, bit [7:0] s0, bit [7:0] s1);
    return {4'b0, s1, s0, 4'b0, 1'b0, ie, div, 2'b0, en};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic run(int n, logic [1:0] a, int mode);
    addr = a;
    repeat (n) begin
      if (mode == 0) evt = {8{$urandom()}};
      else if (mode == 1) evt = '1;
      else evt = '0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    for (int a = 0; a < 4; a++) run(2, a[1:0], 2);
    phase = "R9";
    wr(0, 32'hFFFF_FFFF); run(2, 0, 2);
    wr(0, 32'hF000_0880); run(2, 0, 2);
    phase = "R2";
    wr(0, ctl(0, 0, 0, 8'h05, 8'h07)); run(20, 2, 1); run(5, 1, 1);
    phase = "R3";
    wr(0, ctl(1, 0, 0, 8'hFF, 8'hFF) | 32'h4); run(15, 1, 2);
    wr(0, ctl(1, 1, 0, 8'hFF, 8'hFF) | 32'h4); run(200, 1, 2);
    phase = "R4";
    wr(0, ctl(1, 0, 0, 8'h05, 8'h07)); run(40, 2, 0); run(40, 3, 0);
    wr(0, ctl(1, 0, 0, 8'h0B, 8'hFF)); run(30, 3, 1); run(20, 2, 0);
    phase = "R10";
    wr(0, ctl(1, 0, 0, 8'h00, 8'h06)); evt = '1;
    wr(2, 32'h1234_5678); run(3, 2, 1);
    wr(1, 32'hFFFF_FFFF); run(2, 1, 1);
    wr(3, 32'hFFFF_FFFF); wr(3, 32'h0000_00AA); run(3, 3, 1);
    phase = "R6";
    wr(0, ctl(1, 0, 0, 8'h00, 8'h06) | 32'h0000_0700);
    wr(2, 32'hFFFF_FFFD); run(5, 2, 1); run(2, 0, 1);
    wr(1, 32'hFFFF_FFFE); run(4, 1, 1); run(2, 0, 1);
    phase = "R8";
    wr(0, ctl(1, 0, 3'b001, 8'h00, 8'h06)); run(3, 0, 2);
    wr(0, ctl(1, 0, 3'b110, 8'h00, 8'h06)); run(3, 0, 2);
    phase = "R7";
    wr(0, ctl(1, 0, 3'b111, 8'h00, 8'h06) | 32'h0000_0500); run(3, 0, 2);
    evt = '1;
    wr(3, 32'hFFFF_FFFF);
    wr(0, ctl(1, 0, 3'b111, 8'h00, 8'h06) | 32'h0000_0200); run(3, 0, 1);
    wr(0, ctl(1, 0, 3'b111, 8'h00, 8'h06) | 32'h0000_0200); run(3, 0, 2);
    phase = "R5";
    wr(2, 32'h0000_1000); run(3, 3, 1);
    wr(0, ctl(1, 0, 0, 8'h00, 8'h06) | 32'h2); run(2, 2, 2); run(2, 3, 2);
    wr(0, ctl(1, 1, 0, 8'h00, 8'h06) | 32'h4); run(70, 1, 2); run(2, 0, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule